// File: doc/BRIEF.md
# Real-Time Clock with Alarm, Wrap Warning and Periodic Timer

This block keeps time for a system. A 40-bit counter advances once for every one-cycle pulse on a slow tick-enable input, normally one period of a 32.768 kHz timebase, or about 30.5 µs. At that rate the counter wraps after roughly 388 days. A 40-bit alarm value is compared with the counter. A second compare raises a warning a short time before the counter wraps.

A separate 16-bit down-counter runs from a faster tick-enable, normally about 0.87 µs per tick, so its longest period is near 56.8 ms. It reloads itself each time it expires.

A host reaches every value through a small synchronous register port. The host can read and write the counter, the alarm, the warning threshold and the periodic reload value. It can also read sticky status flags, clear them by writing ones, and choose which flags drive the single interrupt output. Both timebases reach the block as tick-enable pulses that are already synchronous to its clock.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the counter reads 0. It increments by exactly one on each clock cycle where `rtc_tick` is high, and it holds its value on every other cycle.
- R2: On a tick, a counter value of 2^40−1 becomes 0.
- R3: Status bit 0 sets when the counter becomes equal to the 40-bit alarm. The alarm low word is at address 2, and its upper 8 bits are at address 3.
- R4: Status bit 2 sets when the counter becomes equal to {8'hFF, threshold}. The threshold is at address 5 and resets to 0xFFFF_8000, so by default the warning fires 2^15 ticks before the wrap.
- R5: On each `per_tick` the periodic counter decrements. When it is at zero on a tick, it reloads from the reload register (address 4, 16 bits) and sets status bit 1. A period is therefore reload+1 ticks. Writing the reload register also loads the counter.
- R6: Status (address 6) is sticky. Writing a 1 to a bit clears that bit. Writing a 0 leaves the bit unchanged. A flag that is still matching does not set again until its compare becomes true anew.
- R7: `irq` is the OR of the status bits that are enabled in the enable register (address 7, bits 2:0, reset 0).
- R8: A read of the counter low word (address 0) latches the upper 8 bits. A read of address 1 returns that latched byte, so the two reads form one coherent 40-bit value.
- R9: A write to address 0 replaces the counter's low 32 bits. A write to address 1 replaces its upper 8 bits. When a write and a tick fall in the same cycle, the write wins.
- R10: Reset values: the alarm is all ones, the reload value is 0xFFFF, and status is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rtc_tick | input | 1 | One-cycle enable: advance the 40-bit counter |
| per_tick | input | 1 | One-cycle enable: step the periodic counter |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (latches the snapshot at address 0) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | OR of the enabled status flags |

## Verification
The assertions take four things for granted. Both tick inputs are synchronous, one-cycle enables. A write and a read are never issued in the same cycle. The flags are compared against a counter that changes only through ticks or host writes. The stimulus drives every strobe and tick from the falling clock edge for exactly one cycle. It writes 40-bit values low word first, and it chooses orderings so that no half-written value matches a compare by accident. It samples status only after the two register stages between a tick and the flag.

// File: rtl/rtc_pkg.sv
// Package: register addresses, flag positions and shared widths for the
// real-time clock block. Assumes a 32-bit host data path.
package rtc_pkg;
    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 32;
    localparam int NUM_FLAGS = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 4'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 4'd1;
    localparam logic [ADDR_W-1:0] A_ALM_LO = 4'd2;
    localparam logic [ADDR_W-1:0] A_ALM_HI = 4'd3;
    localparam logic [ADDR_W-1:0] A_RELOAD = 4'd4;
    localparam logic [ADDR_W-1:0] A_THRESH = 4'd5;
    localparam logic [ADDR_W-1:0] A_STATUS = 4'd6;
    localparam logic [ADDR_W-1:0] A_ENABLE = 4'd7;

    localparam int F_ALARM  = 0;
    localparam int F_PERIOD = 1;
    localparam int F_WRAP   = 2;
endpackage

// File: rtl/rtc_counter.sv
// Module: 40-bit time counter with an alarm compare and a wrap-warning
// compare. Each compare reports a one-cycle pulse when it becomes true.
// Assumes the tick is a one-cycle enable and that host writes override it.
module rtc_counter #(
    parameter int CNT_W  = 40,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  alarm,
    input  logic [DATA_W-1:0] thresh,
    output logic [CNT_W-1:0]  count,
    output logic              alarm_hit,
    output logic              wrap_hit
);
    localparam int HI_W = CNT_W - DATA_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [1:0] eq_now;
    logic [1:0] eq_q;

    // Counter: a host write takes priority over a tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo || wr_hi) begin
            if (wr_lo) count[DATA_W-1:0]     <= wdata;
            if (wr_hi) count[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
        end else if (tick) begin
            count <= count + ONE;
        end
    end

    // Compare terms: alarm equality, and top byte all ones with the low word at the threshold.
    always_comb begin
        eq_now[0] = (count == alarm);
        eq_now[1] = (&count[CNT_W-1:DATA_W]) && (count[DATA_W-1:0] == thresh);
    end

    // Previous compare state, used to detect when a compare turns true.
    always_ff @(posedge clk) begin
        if (!rst_n) eq_q <= '0;
        else        eq_q <= eq_now;
    end

    assign alarm_hit = eq_now[0] & ~eq_q[0];
    assign wrap_hit  = eq_now[1] & ~eq_q[1];

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_lo && !wr_hi) |=> (count == $past(count) + ONE)); // R1
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_lo && !wr_hi) |=> $stable(count)); // R1
    AST_HIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> !alarm_hit); // R3
endmodule

// File: rtl/rtc_periodic.sv
// Module: periodic down-counter. It reloads at zero and pulses `expire`
// in the same cycle as the reload. Assumes the tick is a one-cycle enable.
module rtc_periodic #(
    parameter int PER_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    input  logic [PER_W-1:0] reload,
    output logic             expire
);
    localparam logic [PER_W-1:0] ONE = PER_W'(1);

    logic [PER_W-1:0] cnt;

    // Down-count with reload at zero; a host load restarts the period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '1;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (load) begin
                cnt <= load_val;
            end else if (tick) begin
                if (cnt == '0) begin
                    cnt    <= reload;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end

    AST_PER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt == '0) |=> (cnt == $past(reload) && expire)); // R5
    AST_PER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt != '0) |=> (cnt == $past(cnt) - ONE && !expire)); // R5
endmodule

// File: rtl/rtc_regs.sv
// Module: host register file. It holds the alarm, threshold, reload value,
// enables, sticky status and the counter snapshot, and it builds the interrupt.
// Assumes one access per cycle with combinational read data.
module rtc_regs
    import rtc_pkg::*;
#(
    parameter int                CNT_W       = 40,
    parameter int                PER_W       = 16,
    parameter logic [DATA_W-1:0] WARN_RESET  = 32'hFFFF_8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              alarm_hit,
    input  logic              wrap_hit,
    input  logic              per_expire,
    output logic              wr_cnt_lo,
    output logic              wr_cnt_hi,
    output logic              per_load,
    output logic [CNT_W-1:0]  alarm,
    output logic [DATA_W-1:0] thresh,
    output logic [PER_W-1:0]  reload,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int HI_W = CNT_W - DATA_W;

    logic [NUM_FLAGS-1:0] status;
    logic [NUM_FLAGS-1:0] enable;
    logic [NUM_FLAGS-1:0] set_v;
    logic [NUM_FLAGS-1:0] clr_v;
    logic [HI_W-1:0]      snap_hi;

    // Write strobes that leave this module.
    assign wr_cnt_lo = wr_en && (addr == A_CNT_LO);
    assign wr_cnt_hi = wr_en && (addr == A_CNT_HI);
    assign per_load  = wr_en && (addr == A_RELOAD);

    // Configuration registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm  <= '1;
            thresh <= WARN_RESET;
            reload <= '1;
            enable <= '0;
        end else if (wr_en) begin
            case (addr)
                A_ALM_LO: alarm[DATA_W-1:0]     <= wdata;
                A_ALM_HI: alarm[CNT_W-1:DATA_W] <= wdata[HI_W-1:0];
                A_RELOAD: reload                <= wdata[PER_W-1:0];
                A_THRESH: thresh                <= wdata;
                A_ENABLE: enable                <= wdata[NUM_FLAGS-1:0];
                default:  ;
            endcase
        end
    end

    // Flag set and clear vectors.
    always_comb begin
        set_v           = '0;
        set_v[F_ALARM]  = alarm_hit;
        set_v[F_PERIOD] = per_expire;
        set_v[F_WRAP]   = wrap_hit;
        clr_v = (wr_en && addr == A_STATUS) ? wdata[NUM_FLAGS-1:0] : '0;
    end

    // Sticky status: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_v) | set_v;
    end

    // Snapshot of the counter's top byte, taken on a low-word read.
    always_ff @(posedge clk) begin
        if (!rst_n)                          snap_hi <= '0;
        else if (rd_en && addr == A_CNT_LO)  snap_hi <= count[CNT_W-1:DATA_W];
    end

    // Read multiplexer.
    always_comb begin
        case (addr)
            A_CNT_LO: rdata = count[DATA_W-1:0];
            A_CNT_HI: rdata = DATA_W'(snap_hi);
            A_ALM_LO: rdata = alarm[DATA_W-1:0];
            A_ALM_HI: rdata = DATA_W'(alarm[CNT_W-1:DATA_W]);
            A_RELOAD: rdata = DATA_W'(reload);
            A_THRESH: rdata = thresh;
            A_STATUS: rdata = DATA_W'(status);
            A_ENABLE: rdata = DATA_W'(enable);
            default:  rdata = '0;
        endcase
    end

    assign irq = |(status & enable);

    AST_ALARM_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> status[F_ALARM]); // R3
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_hit |=> status[F_WRAP]); // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(status) & ~$past(clr_v)) & ~status) == '0)); // R6
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v == '0) |=> ((status & ~$past(status)) == '0)); // R6
endmodule

// File: rtl/rtc_alarm_timer.sv
// Module: top level of the real-time clock. It joins the 40-bit counter,
// the periodic timer and the register file. Assumes both tick inputs are
// one-cycle enables synchronous to clk.
module rtc_alarm_timer
    import rtc_pkg::*;
#(
    parameter int CNT_W = 40,
    parameter int PER_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_tick,
    input  logic              per_tick,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  alarm;
    logic [DATA_W-1:0] thresh;
    logic [PER_W-1:0]  reload;
    logic              alarm_hit, wrap_hit, per_expire;
    logic              wr_cnt_lo, wr_cnt_hi, per_load;

    rtc_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(rtc_tick),
        .wr_lo(wr_cnt_lo), .wr_hi(wr_cnt_hi), .wdata(wdata),
        .alarm(alarm), .thresh(thresh), .count(count),
        .alarm_hit(alarm_hit), .wrap_hit(wrap_hit)
    );

    rtc_periodic #(.PER_W(PER_W)) u_per (
        .clk(clk), .rst_n(rst_n), .tick(per_tick),
        .load(per_load), .load_val(wdata[PER_W-1:0]), .reload(reload),
        .expire(per_expire)
    );

    rtc_regs #(.CNT_W(CNT_W), .PER_W(PER_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .count(count), .alarm_hit(alarm_hit),
        .wrap_hit(wrap_hit), .per_expire(per_expire),
        .wr_cnt_lo(wr_cnt_lo), .wr_cnt_hi(wr_cnt_hi), .per_load(per_load),
        .alarm(alarm), .thresh(thresh), .reload(reload),
        .rdata(rdata), .irq(irq)
    );
endmodule

// File: tb/sim_rtc_alarm_timer.sv
module sim_rtc_alarm_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_tick = 1'b0, per_tick = 1'b0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    int checks = 0, errors = 0;
    logic [31:0] v;

    always #5 clk = ~clk;

    rtc_alarm_timer u0 (.clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick),
        .per_tick(per_tick), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .irq(irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic rtick(input int n);
        repeat (n) begin
            @(negedge clk); rtc_tick = 1'b1;
            @(negedge clk); rtc_tick = 1'b0;
        end
    endtask

    task automatic ptick(input int n);
        repeat (n) begin
            @(negedge clk); per_tick = 1'b1;
            @(negedge clk); per_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        rd(4'd0, v); chk("R1 reset count lo", v, 0);
        rd(4'd1, v); chk("R1 reset count hi", v, 0);
        rd(4'd2, v); chk("R10 alarm lo", v, 32'hFFFF_FFFF);
        rd(4'd3, v); chk("R10 alarm hi", v, 32'hFF);
        rd(4'd4, v); chk("R10 reload", v, 32'hFFFF);
        rd(4'd5, v); chk("R4 default threshold", v, 32'hFFFF_8000);
        rd(4'd6, v); chk("R10 status", v, 0);
        rd(4'd7, v); chk("R7 enable reset", v, 0);
        chk("R7 irq at reset", {31'd0, irq}, 0);
    endtask

    task automatic t_count;
        rtick(3);
        rd(4'd0, v); chk("R1 three ticks", v, 3);
        idle(5);
        rd(4'd0, v); chk("R1 hold without tick", v, 3);
        @(negedge clk); addr = 4'd0; wdata = 32'h10; wr_en = 1'b1; rtc_tick = 1'b1;
        @(negedge clk); wr_en = 1'b0; rtc_tick = 1'b0;
        rd(4'd0, v); chk("R9 write wins over tick", v, 32'h10);
    endtask

    task automatic t_alarm;
        wr(4'd0, 3); wr(4'd1, 0);
        wr(4'd2, 5); wr(4'd3, 0);
        rtick(1); idle(2);
        rd(4'd6, v); chk("R3 no alarm before match", v & 1, 0);
        rtick(1); idle(2);
        rd(4'd6, v); chk("R3 alarm on match", v & 1, 1);
        chk("R7 irq masked", {31'd0, irq}, 0);
        wr(4'd7, 1); #1;
        chk("R7 irq enabled", {31'd0, irq}, 1);
        wr(4'd6, 0);
        rd(4'd6, v); chk("R6 write 0 keeps flag", v & 1, 1);
        wr(4'd6, 1); idle(2);
        rd(4'd6, v); chk("R6 write 1 clears, no re-set while equal", v & 1, 0);
        chk("R7 irq drops", {31'd0, irq}, 0);
    endtask

    task automatic t_periodic;
        wr(4'd7, 2);
        wr(4'd4, 3);
        ptick(3); idle(2);
        rd(4'd6, v); chk("R5 no expiry before reload+1 ticks", v & 2, 0);
        ptick(1); idle(2);
        rd(4'd6, v); chk("R5 expiry after reload+1 ticks", v & 2, 2);
        chk("R7 irq periodic", {31'd0, irq}, 1);
        wr(4'd6, 2);
        ptick(3); idle(2);
        rd(4'd6, v); chk("R5 second period not yet", v & 2, 0);
        ptick(1); idle(2);
        rd(4'd6, v); chk("R5 second period expires", v & 2, 2);
        wr(4'd6, 7); wr(4'd7, 0);
    endtask

    task automatic t_wrap;
        wr(4'd5, 32'h100);
        wr(4'd0, 32'hFF); wr(4'd1, 32'hFE);
        rtick(1); idle(2);
        rd(4'd6, v); chk("R4 no warning unless top byte all ones", v & 4, 0);
        wr(4'd0, 32'hFF); wr(4'd1, 32'hFF);
        rtick(1); idle(2);
        rd(4'd6, v); chk("R4 warning at programmed threshold", v & 4, 4);
        wr(4'd5, 32'hFFFF_8000); wr(4'd6, 4);
        wr(4'd0, 32'hFFFF_7FFF);
        rtick(1); idle(2);
        rd(4'd6, v); chk("R4 warning at default threshold", v & 4, 4);
        wr(4'd0, 32'hFFFF_FFFF);
        rtick(1);
        rd(4'd0, v); chk("R2 wrap low word", v, 0);
        rd(4'd1, v); chk("R2 wrap high byte", v, 0);
    endtask

    task automatic t_snapshot;
        wr(4'd1, 0); wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); chk("R8 low read", v, 32'hFFFF_FFFF);
        rtick(1);
        rd(4'd1, v); chk("R8 high byte from snapshot", v, 0);
        rd(4'd0, v); chk("R8 low after carry", v, 0);
        rd(4'd1, v); chk("R8 new snapshot", v, 1);
    endtask

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle(3); rst_n = 1'b1; idle(1);
        t_reset;
        t_count;
        t_alarm;
        t_periodic;
        t_wrap;
        t_snapshot;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule